// File: doc/BRIEF.md
# Dual-Clock Free-Running Timer with Four Compare Channels

This block is a 32-bit up-counter with four compare channels, placed behind a simple register bus. The counter and its compare logic run on a slow timer clock. The register file runs on a separate bus clock. Nothing from one clock domain is used in the other until a toggle handshake has carried it across. Software never sees the live counter directly. To read it, software asks for a snapshot, waits for the snapshot to complete, and then reads the held value.

Each write to the counter or to a compare register travels to the timer clock domain through its own handshake. Each handshake has its own in-flight flag in an access-status word. While a flag is set, further writes to that register are dropped. A compare hit latches a sticky flag in the bus clock domain. Software clears these flags by writing ones. The flags, gated by per-channel enables, drive one interrupt line.

Top module: `ostmr_timer`

## Requirements
- R1: After reset, the compare registers read 0xFFFFFFFF. The count register, status, interrupt enable, control and access status read 0, and `irq` is low.
- R2: The register map, as byte addresses, is:
  - compare n at 4*n (n = 0 to 3), read back as last accepted;
  - count at 0x10;
  - status at 0x14 (bit n = compare n hit);
  - interrupt enable at 0x1C (bit n enables compare n; bits above 3 read 0);
  - control at 0x20;
  - access status at 0x24.
- R3: A write to count that is accepted loads the counter in the timer clock domain. Access-status bit 4 is 1 from the bus clock edge after the write until the load has been acknowledged.
- R4: Writing control with bit 1 set requests a snapshot. Control bit 1 and access-status bit 5 read 1 until the snapshot returns, then clear by themselves. After that, count reads the value the counter held when the snapshot was taken.
- R5: A write to compare n sets access-status bit n on the next bus clock edge. The bit clears once the new value has reached the timer clock domain.
- R6: A write to count or to compare n, or a snapshot request, is ignored while its own access-status bit is 1.
- R7: With control bit 0 set, the counter advances by one per timer clock and wraps from 0xFFFFFFFF to 0. With bit 0 clear, it holds its value.
- R8: While counting, the cycle in which the counter equals compare n sets status bit n.
- R9: Writing status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: `irq` is high exactly when some status bit n and enable bit n are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus clock domain |
| tmr_clk | input | 1 | Timer clock |
| tmr_rst_n | input | 1 | Synchronous active-low reset, timer clock domain |
| bus_wr_en | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 6 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs the two clocks at unrelated periods, so every handshake completes after a varying number of bus cycles. It samples the in-flight flags right after a write, and again after the flags drop. A design that cleared a flag early, or never set it, fails there. A second write issued back-to-back with the first must leave the first value in place; a design that overwrote the held data would corrupt the value sent across. Starting the counter just below its maximum, with compare 0 set to a small value, catches a counter that saturates or compares with the wrong width. Clearing one status bit at a time catches a write-one-to-clear that wipes the whole word or leaves `irq` stuck high.

// File: rtl/ostmr_pkg.sv
// Package: shared widths, register offsets and access-status bit positions
// for the dual-clock timer. Assumes byte addressing with word-aligned access.
package ostmr_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_MATCH = 4;
    localparam int ADDR_W    = 6;

    localparam logic [ADDR_W-1:0] ADDR_MATCH0 = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 6'h10;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 6'h14;
    localparam logic [ADDR_W-1:0] ADDR_IEN    = 6'h1C;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 6'h20;
    localparam logic [ADDR_W-1:0] ADDR_ACCESS = 6'h24;

    localparam int AS_CNT_WR = 4;
    localparam int AS_SNAP   = 5;
endpackage

// File: rtl/ostmr_sync.sv
// Module: multi-stage flip-flop synchronizer.
// Assumes each bit is independent, or that bits change one at a time (toggles).
module ostmr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the asynchronous input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ostmr_handshake.sv
// Module: toggle request/acknowledge handshake from the bus clock to the timer clock.
// The bus side flips a request bit. The timer side sees the change and gives a
// one-cycle strobe, then echoes the bit back as the acknowledge. busy stays high
// until that echo has been synchronized back. The caller holds any data stable
// while busy is high. A start that arrives while busy is high is dropped.
module ostmr_handshake #(
    parameter int SYNC_STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst_n,
    input  logic tmr_clk,
    input  logic tmr_rst_n,
    input  logic start,
    output logic busy,
    output logic tmr_strobe
);
    logic req_q;
    logic ack_q;
    logic ack_s;
    logic req_s;

    // Bus side: flip the request bit on an accepted start.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            req_q <= 1'b0;
        end else if (start && !busy) begin
            req_q <= ~req_q;
        end
    end

    ostmr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) ack_sync_i (
        .clk(bus_clk), .rst_n(bus_rst_n), .din(ack_q), .dout(ack_s)
    );

    assign busy = req_q ^ ack_s;

    ostmr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) req_sync_i (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .din(req_q), .dout(req_s)
    );

    // Timer side: record the request level last seen; it doubles as the acknowledge.
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= req_s;
        end
    end

    assign tmr_strobe = req_s ^ ack_q;

    // R5
    start_sets_busy_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (start && !busy) |=> busy);

    // R6
    busy_drops_start_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (start && busy) |=> $stable(req_q));
endmodule

// File: rtl/ostmr_core.sv
// Module: timer-domain counter, compare registers and hit detection.
// Runs entirely on tmr_clk. Loads arrive as one-cycle strobes, and their data
// is held stable by the bus side. Each compare hit flips a per-channel toggle
// so that the bus domain can detect it after synchronization.
module ostmr_core #(
    parameter int DATA_W    = 32,
    parameter int NUM_MATCH = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              run_en,
    input  logic                              cnt_load,
    input  logic [DATA_W-1:0]                 cnt_val,
    input  logic [NUM_MATCH-1:0]              mt_load,
    input  logic [NUM_MATCH-1:0][DATA_W-1:0]  mt_val,
    input  logic                              snap_req,
    output logic [DATA_W-1:0]                 snap_val,
    output logic [NUM_MATCH-1:0]              evt_tgl
);
    logic [DATA_W-1:0]                cnt_q;
    logic [NUM_MATCH-1:0][DATA_W-1:0] mt_q;

    // Free-running counter: a load wins over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_load) begin
            cnt_q <= cnt_val;
        end else if (run_en) begin
            cnt_q <= cnt_q + DATA_W'(1);
        end
    end

    // Capture the counter for the bus side when a snapshot is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_val <= '0;
        end else if (snap_req) begin
            snap_val <= cnt_q;
        end
    end

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
        // Compare register, reset to all ones.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mt_q[g] <= '1;
            end else if (mt_load[g]) begin
                mt_q[g] <= mt_val[g];
            end
        end

        // Flip the hit toggle in the cycle the running counter equals the compare value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_tgl[g] <= 1'b0;
            end else if (run_en && (cnt_q == mt_q[g])) begin
                evt_tgl[g] <= ~evt_tgl[g];
            end
        end
    end

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !cnt_load) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_load) |=> $stable(cnt_q));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt_q == $past(cnt_val)));
endmodule

// File: rtl/ostmr_timer.sv
// Module: top of the dual-clock timer.
// Holds the bus-side register file, the handshakes for count writes, compare
// writes and snapshots, the crossing of compare hits back to the bus clock, and
// the interrupt. Assumes single-cycle bus writes and combinational read data.
// The two clocks are unrelated.
module ostmr_timer
    import ostmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              tmr_clk,
    input  logic              tmr_rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NUM_MATCH-1:0][DATA_W-1:0] mt_shadow;
    logic [NUM_MATCH-1:0]             mt_hit;
    logic [NUM_MATCH-1:0]             mt_busy;
    logic [NUM_MATCH-1:0]             mt_strobe;
    logic [DATA_W-1:0]                cnt_wr_q;
    logic [DATA_W-1:0]                cnt_rd_q;
    logic                             cnt_hit;
    logic                             cnt_busy;
    logic                             cnt_strobe;
    logic                             snap_hit;
    logic                             snap_busy;
    logic                             snap_busy_q;
    logic                             snap_strobe;
    logic [DATA_W-1:0]                snap_val;
    logic                             run_q;
    logic                             run_s;
    logic [NUM_MATCH-1:0]             status_q;
    logic [NUM_MATCH-1:0]             ien_q;
    logic [NUM_MATCH-1:0]             evt_tgl;
    logic [NUM_MATCH-1:0]             evt_s;
    logic [NUM_MATCH-1:0]             evt_q;
    logic [NUM_MATCH-1:0]             evt_pulse;
    logic                             status_wr;

    assign cnt_hit   = bus_wr_en && (bus_addr == ADDR_COUNT);
    assign snap_hit  = bus_wr_en && (bus_addr == ADDR_CTRL) && bus_wdata[1];
    assign status_wr = bus_wr_en && (bus_addr == ADDR_STATUS);

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_mt
        assign mt_hit[g] = bus_wr_en && (bus_addr == ADDR_MATCH0 + ADDR_W'(4 * g));

        // Bus copy of compare g; it is also the data carried across.
        always_ff @(posedge bus_clk) begin
            if (!bus_rst_n) begin
                mt_shadow[g] <= '1;
            end else if (mt_hit[g] && !mt_busy[g]) begin
                mt_shadow[g] <= bus_wdata;
            end
        end

        ostmr_handshake #(.SYNC_STAGES(SYNC_STAGES)) mt_hs_i (
            .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
            .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
            .start(mt_hit[g]), .busy(mt_busy[g]), .tmr_strobe(mt_strobe[g])
        );
    end

    // Hold the count value being written until its handshake finishes.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            cnt_wr_q <= '0;
        end else if (cnt_hit && !cnt_busy) begin
            cnt_wr_q <= bus_wdata;
        end
    end

    ostmr_handshake #(.SYNC_STAGES(SYNC_STAGES)) cnt_hs_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .start(cnt_hit), .busy(cnt_busy), .tmr_strobe(cnt_strobe)
    );

    ostmr_handshake #(.SYNC_STAGES(SYNC_STAGES)) snap_hs_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .start(snap_hit), .busy(snap_busy), .tmr_strobe(snap_strobe)
    );

    // When the snapshot handshake completes, copy the held timer value.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            snap_busy_q <= 1'b0;
            cnt_rd_q    <= '0;
        end else begin
            snap_busy_q <= snap_busy;
            if (snap_busy_q && !snap_busy) begin
                cnt_rd_q <= snap_val;
            end
        end
    end

    // Run enable and interrupt-enable registers.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            run_q <= 1'b0;
            ien_q <= '0;
        end else begin
            if (bus_wr_en && (bus_addr == ADDR_CTRL)) begin
                run_q <= bus_wdata[0];
            end
            if (bus_wr_en && (bus_addr == ADDR_IEN)) begin
                ien_q <= bus_wdata[NUM_MATCH-1:0];
            end
        end
    end

    ostmr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) run_sync_i (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .din(run_q), .dout(run_s)
    );

    ostmr_core #(.DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH)) core_i (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .run_en(run_s),
        .cnt_load(cnt_strobe), .cnt_val(cnt_wr_q),
        .mt_load(mt_strobe), .mt_val(mt_shadow),
        .snap_req(snap_strobe), .snap_val(snap_val), .evt_tgl(evt_tgl)
    );

    ostmr_sync #(.WIDTH(NUM_MATCH), .STAGES(SYNC_STAGES)) evt_sync_i (
        .clk(bus_clk), .rst_n(bus_rst_n), .din(evt_tgl), .dout(evt_s)
    );

    // Detect hit toggles; update sticky status, where a set wins over a clear.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            evt_q    <= '0;
            status_q <= '0;
        end else begin
            evt_q    <= evt_s;
            status_q <= (status_q & ~(status_wr ? bus_wdata[NUM_MATCH-1:0] : '0)) | evt_pulse;
        end
    end

    assign evt_pulse = evt_s ^ evt_q;
    assign irq       = |(status_q & ien_q);

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_MATCH; n++) begin
            if (bus_addr == ADDR_MATCH0 + ADDR_W'(4 * n)) begin
                bus_rdata = mt_shadow[n];
            end
        end
        case (bus_addr)
            ADDR_COUNT:  bus_rdata = cnt_rd_q;
            ADDR_STATUS: bus_rdata = DATA_W'(status_q);
            ADDR_IEN:    bus_rdata = DATA_W'(ien_q);
            ADDR_CTRL:   bus_rdata = DATA_W'({snap_busy, run_q});
            ADDR_ACCESS: bus_rdata = DATA_W'({snap_busy, cnt_busy, mt_busy});
            default:     ;
        endcase
    end

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_chk
        // R8
        evt_sets_status_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            evt_pulse[g] |=> status_q[g]);

        // R9
        w1c_clears_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            (status_wr && bus_wdata[g] && !evt_pulse[g]) |=> !status_q[g]);
    end

    // R4
    snap_capture_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (snap_busy_q && !snap_busy) |=> (cnt_rd_q == $past(snap_val)));
endmodule

// File: tb/ostmr_timer_tb.sv
module ostmr_timer_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic        bus_clk = 1'b0;
    logic        tmr_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        tmr_rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [5:0] A_M0 = 6'h00, A_M1 = 6'h04, A_M2 = 6'h08, A_M3 = 6'h0C;
    localparam logic [5:0] A_CNT = 6'h10, A_ST = 6'h14, A_IEN = 6'h1C;
    localparam logic [5:0] A_CTL = 6'h20, A_AS = 6'h24;

    localparam int NV = 7;
    localparam logic [5:0]  TV_ADDR [NV] = '{A_M0, A_M1, A_M2, A_M3, A_IEN, A_IEN, A_IEN};
    localparam logic [31:0] TV_WR   [NV] = '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0,
                                             32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'h5, 32'h0};
    localparam logic [31:0] TV_EXP  [NV] = '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0,
                                             32'hA5A5_A5A5, 32'hF, 32'h5, 32'h0};

    always #2.5 bus_clk = ~bus_clk;
    always #11.5 tmr_clk = ~tmr_clk;

    ostmr_timer dut_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge bus_clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input logic [31:0] mask);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            bus_read(A_AS, v);
            if ((v & mask) == 0) break;
            @(negedge bus_clk);
        end
        @(negedge bus_clk);
    endtask

    task automatic snapshot(input logic run, output logic [31:0] v);
        bus_write(A_CTL, {30'b0, 1'b1, run});
        wait_idle(32'h20);
        bus_read(A_CNT, v);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] s1;
        logic [31:0] s2;
        repeat (6) @(negedge tmr_clk);
        bus_rst_n = 1'b1;
        tmr_rst_n = 1'b1;
        @(negedge bus_clk);

        // R1 reset state
        bus_read(A_M0, v);  check("R1 match0", v, 32'hFFFF_FFFF);
        bus_read(A_M3, v);  check("R1 match3", v, 32'hFFFF_FFFF);
        bus_read(A_CNT, v); check("R1 count", v, 32'h0);
        bus_read(A_ST, v);  check("R1 status", v, 32'h0);
        bus_read(A_IEN, v); check("R1 ien", v, 32'h0);
        bus_read(A_CTL, v); check("R1 ctrl", v, 32'h0);
        bus_read(A_AS, v);  check("R1 access", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 table walk: write, let crossing finish, read back
        for (int i = 0; i < NV; i++) begin
            bus_write(TV_ADDR[i], TV_WR[i]);
            wait_idle(32'h3F);
            bus_read(TV_ADDR[i], v);
            check("R2 readback", v, TV_EXP[i]);
        end

        // R5 busy flag for compare 2 right after a write, then clear
        bus_write(A_M2, 32'h0000_7000);
        bus_read(A_AS, v); check("R5 busy set", v & 32'h4, 32'h4);
        wait_idle(32'h4);
        bus_read(A_AS, v); check("R5 busy clear", v & 32'h4, 32'h0);

        // R6 back-to-back write to compare 1: the second is dropped
        bus_write(A_M1, 32'h1111_0000);
        bus_write(A_M1, 32'h2222_0000);
        bus_read(A_M1, v); check("R6 match1 in flight", v, 32'h1111_0000);
        wait_idle(32'h2);
        bus_read(A_M1, v); check("R6 match1 kept", v, 32'h1111_0000);

        // R3 count write while stopped, R4 snapshot readback
        bus_write(A_CNT, 32'h0000_0500);
        bus_read(A_AS, v); check("R3 count busy", v & 32'h10, 32'h10);
        wait_idle(32'h10);
        bus_write(A_CTL, 32'h2);
        bus_read(A_AS, v);  check("R4 snap busy", v & 32'h20, 32'h20);
        bus_read(A_CTL, v); check("R4 ctrl bit1 set", v & 32'h2, 32'h2);
        wait_idle(32'h20);
        bus_read(A_CTL, v); check("R4 ctrl bit1 clear", v & 32'h2, 32'h0);
        bus_read(A_CNT, v); check("R3 R4 count value", v, 32'h0000_0500);

        // R6 count write ignored while busy
        bus_write(A_CNT, 32'h0000_0600);
        bus_write(A_CNT, 32'h0000_0700);
        wait_idle(32'h10);
        snapshot(1'b0, v); check("R6 count kept", v, 32'h0000_0600);

        // R7 counting advances, then holds
        bus_write(A_CTL, 32'h1);
        repeat (200) @(negedge bus_clk);
        snapshot(1'b1, s1);
        repeat (200) @(negedge bus_clk);
        snapshot(1'b1, s2);
        check("R7 advances", {31'b0, (s2 > s1) && (s2 - s1 < 32'd200)}, 32'h1);
        bus_write(A_CTL, 32'h0);
        repeat (40) @(negedge bus_clk);
        snapshot(1'b0, s1);
        repeat (100) @(negedge bus_clk);
        snapshot(1'b0, s2);
        check("R7 holds", s2, s1);

        // R8 R9 R10 compare hits and interrupt gating
        bus_write(A_CNT, 32'd100);
        bus_write(A_M0, 32'd110);
        bus_write(A_M3, 32'd105);
        wait_idle(32'h3F);
        bus_write(A_ST, 32'hF);
        bus_write(A_CTL, 32'h1);
        repeat (200) @(negedge bus_clk);
        bus_write(A_CTL, 32'h0);
        repeat (20) @(negedge bus_clk);
        bus_read(A_ST, v); check("R8 status hits", v, 32'h9);
        check("R10 irq masked", {31'b0, irq}, 32'h0);
        bus_write(A_IEN, 32'h1);
        check("R10 irq ch0", {31'b0, irq}, 32'h1);
        bus_write(A_IEN, 32'h8);
        check("R10 irq ch3", {31'b0, irq}, 32'h1);
        bus_write(A_ST, 32'h1);
        bus_read(A_ST, v); check("R9 clear bit0 only", v, 32'h8);
        check("R10 irq still ch3", {31'b0, irq}, 32'h1);
        bus_write(A_IEN, 32'h1);
        check("R10 irq gated off", {31'b0, irq}, 32'h0);
        bus_write(A_ST, 32'h8);
        bus_read(A_ST, v); check("R9 clear bit3", v, 32'h0);

        // R7 R8 wrap through 0xFFFFFFFF to a small compare value
        bus_write(A_CNT, 32'hFFFF_FFF0);
        bus_write(A_M0, 32'h2);
        wait_idle(32'h3F);
        bus_write(A_ST, 32'hF);
        bus_write(A_CTL, 32'h1);
        repeat (250) @(negedge bus_clk);
        snapshot(1'b0, v);
        check("R7 wrapped small", {31'b0, v < 32'h100}, 32'h1);
        repeat (20) @(negedge bus_clk);
        bus_read(A_ST, v); check("R8 hit after wrap", v & 32'h1, 32'h1);
        check("R10 irq after wrap", {31'b0, irq}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule